// File: doc/BRIEF.md
# Boolean-to-Arithmetic Mask Converter

This block takes a secret word that is hidden under a Boolean (XOR) mask and re-hides it under an additive mask. It receives the masked word `bool_val_i` (the secret XOR the mask) and the mask `bool_mask_i`. It returns `arith_val_o`, which is the secret plus the same mask, modulo 2^WIDTH. The secret itself never appears on any wire. The block is purely combinational and sits in front of ordinary adders that work on arithmetically masked operands.

The conversion is a ripple chain of two-input multiplexers, one per bit, which maps onto a fast carry structure. The masked input bit steers each multiplexer. When that bit is 0, the stage takes the mask bit as its carry; when it is 1, the stage passes on the incoming carry.

A plain version of this chain would put the mask bit on a data input that is statistically tied to the select. To avoid that, one fresh random bit `carry_rand_i` is XORed onto:
- every data input,
- every carry passed along the chain,
- the seed of the chain.

A final XOR per bit removes that random bit again when the output is formed. The carry out of the top bit is dropped.

Top module: `b2a_mask_converter`

## Requirements
- R1: For all inputs, `arith_val_o` equals ((`bool_val_i` XOR `bool_mask_i`) + `bool_mask_i`) mod 2^WIDTH.
- R2: Bit 0 of `arith_val_o` always equals bit 0 of `bool_val_i`.
- R3: When `bool_val_i` is all ones, `arith_val_o` equals `bool_val_i`, whatever the mask.
- R4: When `bool_val_i` is zero, `arith_val_o` equals `bool_mask_i` shifted left by one, with the top bit dropped.
- R5: The random bit `carry_rand_i` has no effect on `arith_val_o`: both values give the same output for the same word and mask.
- R6: A carry out of the top bit is discarded. With secret all ones and mask 1, the output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bool_val_i | input | WIDTH | Secret word XOR its mask |
| bool_mask_i | input | WIDTH | Mask word, reused as the additive mask |
| carry_rand_i | input | 1 | Fresh random bit that hides the carry chain |
| arith_val_o | output | WIDTH | Secret plus mask, modulo 2^WIDTH |

## Verification
The assertions assume the three inputs are two-state. They are skipped while any input bit is unknown, which covers the moments before the bench first drives the block. The bench holds all inputs at defined values from the first clock onward and only changes them away from the sampling instant. It sweeps every word, mask and random-bit combination of a 6-bit instance. It drives the 32-bit instance with corner words and pseudo-random words.

// File: rtl/b2a_pkg.sv
package b2a_pkg;

  // One stage of the masked carry chain: the masked word bit selects
  // between the masked incoming carry and the masked mask bit.
  function automatic logic carry_step(input logic sel,
                                      input logic rbit_q,
                                      input logic cin_q);
    return sel ? cin_q : rbit_q;
  endfunction

  // Output bit: word bit XOR masked carry XOR random bit (strips the random bit).
  function automatic logic strip_bit(input logic wbit,
                                     input logic cin_q,
                                     input logic q);
    return wbit ^ cin_q ^ q;
  endfunction

endpackage

// File: rtl/b2a_carry_cell.sv
module b2a_carry_cell
  import b2a_pkg::*;
(
  input  logic sel_i,
  input  logic rbit_i,
  input  logic q_i,
  input  logic cin_q_i,
  output logic cout_q_o
);
  logic rbit_q;

  always_comb begin
    rbit_q   = rbit_i ^ q_i;
    cout_q_o = carry_step(sel_i, rbit_q, cin_q_i);
  end
endmodule

// File: rtl/b2a_carry_chain.sv
module b2a_carry_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             q_i,
  output logic [WIDTH-1:0] cin_q_o
);
  logic [WIDTH-1:0] chain_q;

  assign chain_q[0] = q_i;

  // The top stage is not built: its carry out would be discarded.
  for (genvar j = 0; j < WIDTH - 1; j++) begin : g_stage
    b2a_carry_cell u_cell (
      .sel_i   (word_i[j]),
      .rbit_i  (mask_i[j]),
      .q_i     (q_i),
      .cin_q_i (chain_q[j]),
      .cout_q_o(chain_q[j+1])
    );
  end

  assign cin_q_o = chain_q;
endmodule

// File: rtl/b2a_unmask.sv
module b2a_unmask
  import b2a_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  input  logic [WIDTH-1:0] cin_q_i,
  input  logic             q_i,
  output logic [WIDTH-1:0] sum_o
);
  always_comb begin
    for (int j = 0; j < WIDTH; j++) begin
      sum_o[j] = strip_bit(word_i[j], cin_q_i[j], q_i);
    end
  end
endmodule

// File: rtl/b2a_mask_converter.sv
module b2a_mask_converter #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] bool_val_i,
  input  logic [WIDTH-1:0] bool_mask_i,
  input  logic             carry_rand_i,
  output logic [WIDTH-1:0] arith_val_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // Masked carry entering each bit, brought out for the assertions.
  logic [WIDTH-1:0] carry_in_q;

  b2a_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .word_i (bool_val_i),
    .mask_i (bool_mask_i),
    .q_i    (carry_rand_i),
    .cin_q_o(carry_in_q)
  );

  b2a_unmask #(.WIDTH(WIDTH)) u_unmask (
    .word_i (bool_val_i),
    .cin_q_i(carry_in_q),
    .q_i    (carry_rand_i),
    .sum_o  (arith_val_o)
  );

  // Checks are skipped while any input bit is unknown.
  always_comb begin
    if (!$isunknown({bool_val_i, bool_mask_i, carry_rand_i})) begin
      p_sum_r1: assert (arith_val_o == WIDTH'((bool_val_i ^ bool_mask_i) + bool_mask_i))
        else $error("R1 sum mismatch");
      p_low_bit_r2: assert (arith_val_o[0] == bool_val_i[0])
        else $error("R2 low bit mismatch");
      if (bool_val_i == ALL_ONES) begin
        p_all_ones_r3: assert (arith_val_o == bool_val_i)
          else $error("R3 all-ones word altered");
      end
      if (bool_val_i == '0) begin
        p_zero_word_r4: assert (arith_val_o == WIDTH'(bool_mask_i << 1))
          else $error("R4 zero word mismatch");
      end
      // Chain seed equals the random bit; this keeps R5 intact at bit 0.
      p_seed_r5: assert (carry_in_q[0] == carry_rand_i)
        else $error("R5 chain seed not masked");
    end
  end
endmodule

// File: tb/b2a_mask_converter_test.sv
module b2a_mask_converter_test;
  localparam int W  = 32;
  localparam int WS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]  bv, bm, ay;
  logic          q;
  logic [WS-1:0] sbv, sbm, say;
  logic          sq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  b2a_mask_converter #(.WIDTH(W)) uut (
    .bool_val_i(bv), .bool_mask_i(bm), .carry_rand_i(q), .arith_val_o(ay));

  b2a_mask_converter #(.WIDTH(WS)) uut_small (
    .bool_val_i(sbv), .bool_mask_i(sbm), .carry_rand_i(sq), .arith_val_o(say));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive the wide instance at the falling edge; sample one ns later.
  task automatic apply(input logic [W-1:0] secret, input logic [W-1:0] mask, input logic qq);
    @(negedge clk);
    bv = secret ^ mask;
    bm = mask;
    q  = qq;
    #1;
  endtask

  initial begin
    bv = '0; bm = '0; q = 1'b0;
    sbv = '0; sbm = '0; sq = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle inputs: zero word and mask give zero (R1).
    apply('0, '0, 1'b0);
    check("R1 idle", ay, '0);

    // R6: secret all ones, mask 1: the sum wraps to zero.
    apply('1, 32'h1, 1'b1);
    check("R6 wrap", ay, '0);
    apply('1, 32'h1, 1'b0);
    check("R6 wrap q0", ay, '0);

    // R3: masked word all ones, so the secret is the inverted mask.
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] m;
      m = $urandom();
      apply(~m, m, k[0]);
      check("R3 all-ones word", ay, '1);
    end

    // R4: masked word zero, so the secret equals the mask.
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] m;
      m = (k == 0) ? '1 : $urandom();
      apply(m, m, k[1]);
      check("R4 zero word", ay, m + m);
    end

    // R1, R2, R5: pseudo-random words, each under both random-bit values.
    for (int k = 0; k < 600; k++) begin
      logic [W-1:0] s, m, y0;
      s = $urandom();
      m = $urandom();
      apply(s, m, 1'b0);
      y0 = ay;
      check("R1 random", ay, s + m);
      check("R2 low bit", {{(W-1){1'b0}}, ay[0]}, {{(W-1){1'b0}}, bv[0]});
      apply(s, m, 1'b1);
      check("R5 q independence", ay, y0);
    end

    // Exhaustive sweep of the 6-bit instance (R1, R5).
    for (int s = 0; s < (1 << WS); s++) begin
      for (int m = 0; m < (1 << WS); m++) begin
        logic [WS-1:0] y0, expv;
        expv = WS'(s + m);
        @(negedge clk);
        sbv = WS'(s ^ m); sbm = WS'(m); sq = 1'b0;
        #1;
        y0 = say;
        check("R1 sweep", {{(W-WS){1'b0}}, say}, {{(W-WS){1'b0}}, expv});
        sq = 1'b1;
        #1;
        check("R5 sweep", {{(W-WS){1'b0}}, say}, {{(W-WS){1'b0}}, y0});
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Watchdog: an expired run counts as one failed check.
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule